// File: doc/BRIEF.md
# Operating-System Tick Timer Channel

This block is a single 32-bit timer channel for an operating-system scheduler. Software drives it through a small register port. It can write the compare value and the mode, read back the live count and a running flag, and pulse start and stop through two write-only trigger locations. The running flag is read-only and separate from the triggers. Software that has issued a stop polls the flag until it reads zero, which confirms that the stop has taken effect.

The block has two modes. In interval mode the counter loads the compare value and counts down to zero. At zero it raises a one-cycle interrupt and reloads, so a compare value of N-1 gives one interrupt every N clocks. In free-running mode the counter clears at start and counts up through the full range, wrapping at the top. The interrupt fires in the cycle the count equals the compare value.

The mode and compare value are captured when the timer starts. Writing them while the timer runs changes only the next run.

Top module: `tick_timer_channel`

## Requirements
- R1: Registers sit at these byte offsets: compare 0x00 (read/write, 32 bits, one byte-enable per byte lane), count 0x04 (read-only), running flag 0x10 (read-only, bit 0), start trigger 0x14, stop trigger 0x18, mode 0x20. Read data appears on the clock after the read request. The trigger offsets and unmapped offsets read as zero.
- R2: Bit 0 of the running flag reads 1 while the counter runs. It reads 0 from the clock after a stop write takes effect.
- R3: Writing a 1 in bit 0 (byte lane 0) to the start trigger starts the count, and doing the same to the stop trigger halts it. A write with bit 0 clear, to either trigger, has no effect.
- R4: Mode bit 1 selects the mode: 0 is interval and 1 is free-running. The other mode bits are not stored and read as 0.
- R5: In interval mode, the count is loaded with the compare value at start and decrements each clock. When it is zero, the next clock reloads the compare value and raises the interrupt for exactly one cycle. The result is a period of compare+1 clocks.
- R6: In free-running mode, the count is zero after start and rises by one each clock, wrapping from all-ones to zero.
- R7: In free-running mode, the interrupt is high for one cycle, namely the cycle in which the count equals the compare value. A compare value of zero matches only at wrap-around.
- R8: Compare or mode writes made while the timer runs do not change the current run. They take effect at the next start.
- R9: A start written while the timer is running restarts the count from its initial value.
- R10: While stopped, the count holds its value and the interrupt stays low.
- R11: After reset the compare value, count, mode, running flag, read data and interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the following corner cases:
- **Off-by-one in the interval period.** A design that got this wrong would give compare or compare+2 clocks instead of compare+1.
- **A free-running match that lands one cycle late.** The interrupt would then rise while the count already shows compare+1.
- **A compare value of zero in free-running mode.** A wrong design would fire at start or every cycle, when it should stay silent.
- **Compare or mode writes during a run.** A design that takes them live would change the period at once, when it should wait for the next start.
- **Zero writes to the triggers.** A design that decoded only the address would stop or start on them.
- **A stop followed directly by a status read.** A design with a lagging flag would still report running.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int OFF_CMP  = 'h00;
  localparam int OFF_CNT  = 'h04;
  localparam int OFF_RUN  = 'h10;
  localparam int OFF_GO   = 'h14;
  localparam int OFF_HALT = 'h18;
  localparam int OFF_MODE = 'h20;
  localparam int MODE_BIT = 1;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [NB-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cnt_in,
  input  logic          run_in,
  output logic [DW-1:0] cmp_out,
  output logic          free_out,
  output logic          go_p,
  output logic          halt_p
);
  logic [DW-1:0] cmp_q;
  logic          free_q;
  logic [DW-1:0] rd_q;
  logic          wr, rd, lane0_set;

  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign lane0_set = bus_be[0] && bus_wdata[0];
  assign go_p      = wr && bus_addr == AW'(OFF_GO)   && lane0_set;
  assign halt_p    = wr && bus_addr == AW'(OFF_HALT) && lane0_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      free_q <= 1'b0;
    end else if (wr) begin
      if (bus_addr == AW'(OFF_CMP)) begin
        for (int b = 0; b < NB; b++)
          if (bus_be[b]) cmp_q[8*b +: 8] <= bus_wdata[8*b +: 8];
      end
      if (bus_addr == AW'(OFF_MODE) && bus_be[0])
        free_q <= bus_wdata[MODE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd) begin
      unique case (bus_addr)
        AW'(OFF_CMP):  rd_q <= cmp_q;
        AW'(OFF_CNT):  rd_q <= cnt_in;
        AW'(OFF_RUN):  rd_q <= DW'(run_in);
        AW'(OFF_MODE): rd_q <= DW'(free_q) << MODE_BIT;
        default:       rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_q;
  assign cmp_out   = cmp_q;
  assign free_out  = free_q;

  a_r3_one_trigger: assert property (@(posedge clk) disable iff (rst)
    !(go_p && halt_p));
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_p,
  input  logic          halt_p,
  input  logic [DW-1:0] cmp_in,
  input  logic          free_in,
  output logic [DW-1:0] cnt_out,
  output logic          run_out,
  output logic          irq_out
);
  logic [DW-1:0] cnt_q, act_cmp, cnt_inc;
  logic          run_q, act_free, irq_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      act_cmp  <= '0;
      run_q    <= 1'b0;
      act_free <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (go_p) begin
        run_q    <= 1'b1;
        act_cmp  <= cmp_in;
        act_free <= free_in;
        cnt_q    <= free_in ? '0 : cmp_in;
      end else if (halt_p) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (act_free) begin
          cnt_q <= cnt_inc;
          irq_q <= (cnt_inc == act_cmp);
        end else if (cnt_q == '0) begin
          cnt_q <= act_cmp;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_out = cnt_q;
  assign run_out = run_q;
  assign irq_out = irq_q;

  a_r3_start_runs: assert property (@(posedge clk) disable iff (rst)
    go_p |=> run_q);
  a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (halt_p && !go_p) |=> !run_q);
  a_r10_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !go_p) |=> ($stable(cnt_q) && !irq_q));
  a_r6_free_step: assert property (@(posedge clk) disable iff (rst)
    (run_q && act_free && !go_p && !halt_p) |=> cnt_q == DW'($past(cnt_q) + 1'b1));
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !act_free) |-> cnt_q == act_cmp);
  a_r7_match: assert property (@(posedge clk) disable iff (rst)
    (irq_q && act_free) |-> cnt_q == act_cmp);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !act_free && act_cmp != '0 && !go_p) |=> !irq_q);
endmodule

// File: rtl/tick_timer_channel.sv
module tick_timer_channel #(
  parameter int DW = 32,
  parameter int AW = 6,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [NB-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [DW-1:0] cmp_w, cnt_w;
  logic          free_w, run_w, go_w, halt_w;

  tick_timer_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_in(cnt_w), .run_in(run_w),
    .cmp_out(cmp_w), .free_out(free_w), .go_p(go_w), .halt_p(halt_w)
  );

  tick_timer_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .go_p(go_w), .halt_p(halt_w),
    .cmp_in(cmp_w), .free_in(free_w),
    .cnt_out(cnt_w), .run_out(run_w), .irq_out(irq)
  );
endmodule

// File: tb/tick_timer_channel_bench.sv
module tick_timer_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, fails = 0, cycles = 0;
  string rd_tag = "R1";

  always #2 clk = ~clk;

  tick_timer_channel u_tick_timer_channel (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cmp = 0, m_cnt = 0, m_acmp = 0, m_rd = 0;
  logic        m_mode = 0, m_free = 0, m_run = 0, m_irq = 0;
  bit          m_rdv = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cmp = 0; m_cnt = 0; m_acmp = 0; m_rd = 0;
      m_mode = 0; m_free = 0; m_run = 0; m_irq = 0; m_rdv = 0;
    end else begin
      bit go, stop;
      m_rdv = 0;
      if (bus_en && !bus_we) begin
        m_rdv = 1;
        case (bus_addr)
          6'h00: m_rd = m_cmp;
          6'h04: m_rd = m_cnt;
          6'h10: m_rd = {31'd0, m_run};
          6'h20: m_rd = {30'd0, m_mode, 1'b0};
          default: m_rd = 0;
        endcase
      end
      go   = bus_en && bus_we && bus_addr == 6'h14 && bus_be[0] && bus_wdata[0];
      stop = bus_en && bus_we && bus_addr == 6'h18 && bus_be[0] && bus_wdata[0];
      m_irq = 0;
      if (go) begin
        m_run = 1; m_acmp = m_cmp; m_free = m_mode;
        m_cnt = m_mode ? 0 : m_cmp;
      end else if (stop) m_run = 0;
      else if (m_run) begin
        if (m_free) begin
          m_cnt = m_cnt + 1;
          m_irq = (m_cnt == m_acmp);
        end else if (m_cnt == 0) begin
          m_cnt = m_acmp; m_irq = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (bus_en && bus_we && bus_addr == 6'h00)
        for (int b = 0; b < 4; b++) if (bus_be[b]) m_cmp[8*b +: 8] = bus_wdata[8*b +: 8];
      if (bus_en && bus_we && bus_addr == 6'h20 && bus_be[0]) m_mode = bus_wdata[1];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(irq == m_irq, m_free ? "R7 irq" : "R5 irq", {31'd0, irq}, {31'd0, m_irq});
      if (m_rdv) chk(bus_rdata == m_rd, rd_tag, bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    rd_tag = tag;
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(input int exp, input string tag);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 2000);
    chk(n == exp, tag, n, exp);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(irq == 0, "R11 irq", {31'd0, irq}, 0);
    chk(bus_rdata == 0, "R11 rdata", bus_rdata, 0);
    rd(6'h00, "R11 cmp"); rd(6'h04, "R11 cnt"); rd(6'h10, "R11 run"); rd(6'h20, "R11 mode");
    // R1 byte lanes, unmapped reads
    wr(6'h00, 32'hAABBCCDD, 4'hF);
    wr(6'h00, 32'h00000011, 4'b0001);
    rd(6'h00, "R1 byte write");
    chk(bus_rdata == 32'hAABBCC11, "R1 byte lane", bus_rdata, 32'hAABBCC11);
    rd(6'h14, "R1 trigger reads zero"); rd(6'h3C, "R1 unmapped");
    // R4 mode register
    wr(6'h20, 32'hFF, 4'h1); rd(6'h20, "R4 mode bits");
    chk(bus_rdata == 32'h2, "R4 mode readback", bus_rdata, 2);
    wr(6'h20, 32'h0, 4'h1);
    // R5 interval, cmp=4 -> period 5
    wr(6'h00, 32'd4, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, "R5 loaded count");
    rd(6'h10, "R2 running");
    chk(bus_rdata == 1, "R2 flag set", bus_rdata, 1);
    period(5, "R5 period");
    // R3 zero-write to stop ignored
    wr(6'h18, 32'h0, 4'h1); rd(6'h10, "R3 zero stop");
    chk(bus_rdata == 1, "R3 still running", bus_rdata, 1);
    // R8 compare write during run
    wr(6'h00, 32'd9, 4'hF);
    period(5, "R8 period unchanged");
    wr(6'h14, 32'h1, 4'h1);
    period(10, "R8 new compare at restart");
    // R9 restart mid-count
    idle(4);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, "R9 restart count");
    idle(12);
    // R2 stop then immediate status
    wr(6'h18, 32'h1, 4'h1);
    rd(6'h10, "R2 stopped");
    chk(bus_rdata == 0, "R2 flag clear", bus_rdata, 0);
    // R10 holds while stopped
    rd(6'h04, "R10 hold a"); idle(7); rd(6'h04, "R10 hold b");
    wr(6'h14, 32'h0, 4'h1); rd(6'h10, "R3 zero start");
    // R6/R7 free-running, compare 0x10
    wr(6'h20, 32'h2, 4'h1);
    wr(6'h00, 32'h10, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, "R6 count after start");
    idle(20);
    rd(6'h04, "R6 count rises");
    // R8 mode write during run ignored until restart
    wr(6'h20, 32'h0, 4'h1);
    rd(6'h04, "R8 still free-running");
    // R7 compare zero: never matches short of wrap
    wr(6'h20, 32'h2, 4'h1);
    wr(6'h00, 32'h0, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    pulses = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (irq) pulses++; end
    chk(pulses == 0, "R7 compare zero silent", pulses, 0);
    // R7 large compare, near-top values
    wr(6'h00, 32'hFFFFFFFF, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    idle(10);
    rd(6'h04, "R6 count large cmp");
    wr(6'h18, 32'h1, 4'h1);
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule